// File: doc/BRIEF.md
# Prescaled Reload-to-Top PWM Timer

This block is an 8-bit up-counter paced by a 7-bit binary prescaler. The prescaler is fed either by the system clock or by rising edges of an external clock pin, and a 3-bit code picks the division ratio, from 1 to 128. The counter does not run from zero to a period. It climbs from a programmable start value to FFh, and on the next tick it reloads that start value and raises an overflow flag. Raising the start value shortens the period and lowers the PWM resolution. A start value of 00h gives the full 256-step period.

Software reaches four byte-wide registers over a single-cycle register bus. The control register holds the clock source, the divide code, run enable, a self-clearing force-reload command and the overflow interrupt enable. It also reports the overflow flag, and reading it clears that flag. The live count can be read and overwritten while the counter runs. The reload register holds the start value. A duty register sets the count at which the PWM output flips.

At every reload the PWM output takes the level on a polarity input. When the count later reaches the duty value, the output goes to the opposite level. A new duty value is staged and only applies from the next reload or forced reload, so a period is never cut short.

Top module: `arpwm_timer`

## Requirements
- R1: After reset every register reads 00h, and `irq` and `pwm_out` are 0. The register map is: address 0 control, 1 live count, 2 reload value, 3 duty. The control byte is, from bit 7 down: clock-source select, divide code (3 bits), run, force-reload, overflow interrupt enable, overflow flag.
- R2: When the source-select bit is 1, the prescaler advances only on rising edges of `ext_clk`, taken through a two-flop synchronizer. A steady `ext_clk` never advances the count. When the bit is 0, the prescaler advances on every system clock.
- R3: With divide code c, the counter steps once every 2^c prescaler input events. Code 000 steps on every event and code 111 steps on every 128th event.
- R4: While the run bit is 0, the prescaler and the counter hold their values. Clearing and then setting the run bit resumes the prescaler from the phase it held.
- R5: Writing a 1 to the force-reload bit loads the reload value into the counter and clears the prescaler in the same cycle. This bit always reads back as 0.
- R6: A counter step from FFh loads the reload value instead of 00h and sets the overflow flag.
- R7: A read of the control register clears the overflow flag. If an overflow happens in the same cycle as that read, the flag stays set.
- R8: `irq` is 1 exactly while both the overflow flag and the interrupt enable bit are 1.
- R9: Software can write the count register while the counter runs. The written value replaces the count, takes priority over a step in the same cycle, and counting continues from it.
- R10: At each reload, natural or forced, `pwm_out` takes the level of `pwm_pol`, and the staged duty value becomes active. When a step brings the count to the active duty value, `pwm_out` takes the inverse of `pwm_pol`. A duty write made mid-period does not change the current period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_clk | input | 1 | External count source, asynchronous |
| pwm_pol | input | 1 | Level driven on the PWM output at each reload |
| bus_wr | input | 1 | Register write strobe, one cycle |
| bus_rd | input | 1 | Register read strobe, one cycle |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Overflow interrupt request |
| pwm_out | output | 1 | PWM output |

## Verification
The count is sampled at exact cycle offsets after a forced reload, at divide codes 0, 3 and 7. These samples separate a correct power-of-two divider from an off-by-one divider, and from a prescaler that is not cleared on force-reload or is reset on a pause. A burst of external pulses followed by a long steady level shows whether only synchronized rising edges count. A start value of F0h makes the counter wrap quickly, so the wrapped count, a flag read in the wrap cycle (set wins), and the masked and unmasked interrupt can all be observed. Changing the duty value mid-period, and changing the polarity input, shows whether the compare and the reload levels take effect only at reload.

// File: rtl/arpwm_timer.sv
module arpwm_timer #(
  parameter int PRE_W = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ext_clk,
  input  logic       pwm_pol,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       irq,
  output logic       pwm_out
);
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_CNT  = 2'd1;
  localparam logic [1:0] A_RLD  = 2'd2;
  localparam logic [1:0] A_DUTY = 2'd3;

  logic             src_sel, run, ovf_ie, ovf;
  logic [2:0]       div_code;
  logic [7:0]       cnt, rld, duty_buf, duty_act;
  logic [PRE_W-1:0] pre, pre_mask;
  logic [2:0]       ext_sync;

  wire wr_ctrl  = bus_wr && bus_addr == A_CTRL;
  wire wr_cnt   = bus_wr && bus_addr == A_CNT;
  wire rd_ctrl  = bus_rd && bus_addr == A_CTRL;
  wire force_ld = wr_ctrl && bus_wdata[2];

  wire ext_rise = ext_sync[1] & ~ext_sync[2];
  wire src_tick = src_sel ? ext_rise : 1'b1;
  assign pre_mask = ~({PRE_W{1'b1}} << div_code);
  wire step     = run && src_tick && ((pre & pre_mask) == pre_mask);
  wire cnt_wrap = step && cnt == 8'hFF && !force_ld && !wr_cnt;
  wire [7:0] cnt_nx = cnt + 8'd1;

  assign irq = ovf & ovf_ie;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ext_sync <= '0;
    else        ext_sync <= {ext_sync[1:0], ext_clk};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      src_sel  <= 1'b0;
      div_code <= '0;
      run      <= 1'b0;
      ovf_ie   <= 1'b0;
    end else if (wr_ctrl) begin
      src_sel  <= bus_wdata[7];
      div_code <= bus_wdata[6:4];
      run      <= bus_wdata[3];
      ovf_ie   <= bus_wdata[1];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rld      <= '0;
      duty_buf <= '0;
    end else if (bus_wr) begin
      if (bus_addr == A_RLD)  rld      <= bus_wdata;
      if (bus_addr == A_DUTY) duty_buf <= bus_wdata;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                pre <= '0;
    else if (force_ld)         pre <= '0;
    else if (run && src_tick)  pre <= pre + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        cnt <= '0;
    else if (force_ld) cnt <= rld;
    else if (wr_cnt)   cnt <= bus_wdata;
    else if (cnt_wrap) cnt <= rld;
    else if (step)     cnt <= cnt_nx;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        ovf <= 1'b0;
    else if (cnt_wrap) ovf <= 1'b1;
    else if (rd_ctrl)  ovf <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pwm_out  <= 1'b0;
      duty_act <= '0;
    end else if (force_ld || cnt_wrap) begin
      pwm_out  <= pwm_pol;
      duty_act <= duty_buf;
    end else if (step && !wr_cnt && cnt_nx == duty_act) begin
      pwm_out  <= ~pwm_pol;
    end

  always_comb
    case (bus_addr)
      A_CTRL:  bus_rdata = {src_sel, div_code, run, 1'b0, ovf_ie, ovf};
      A_CNT:   bus_rdata = cnt;
      A_RLD:   bus_rdata = rld;
      default: bus_rdata = duty_buf;
    endcase

  AST_EXT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    run && src_sel && !ext_rise && !force_ld |=> pre == $past(pre)); // R2
  AST_FROZEN_CNT: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !bus_wr |=> $stable(cnt) && $stable(pre)); // R4
  AST_FORCE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    force_ld |=> cnt == $past(rld) && pre == '0); // R5
  AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wrap |=> cnt == $past(rld) && ovf); // R6
  AST_CLR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ctrl && !cnt_wrap |=> !ovf); // R7
  AST_PWM_AT_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wrap |=> pwm_out == $past(pwm_pol)); // R10
endmodule

// File: tb/arpwm_timer_tb.sv
module arpwm_timer_tb;
  logic       clk = 1'b0, rst_n = 1'b0, ext_clk = 1'b0, pwm_pol = 1'b0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       irq, pwm_out;
  int n_chk = 0, n_fail = 0, pcnt = 0, base = 0;

  arpwm_timer u_dut (.clk(clk), .rst_n(rst_n), .ext_clk(ext_clk), .pwm_pol(pwm_pol),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq), .pwm_out(pwm_out));

  always #5 clk = ~clk;
  always @(posedge clk) pcnt++;

  function automatic logic [7:0] ctl(input bit sel, input int cc, input bit en, input bit frc, input bit ie);
    return {sel, 3'(cc), en, frc, ie, 1'b0};
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
    logic [7:0] v;
    bus_rd = 1'b1; bus_addr = a;
    #1 v = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
    chk(tag, v, exp);
  endtask

  task automatic at(input int k);
    while (pcnt < base + k) @(negedge clk);
  endtask

  task automatic start(input logic [7:0] reload, input logic [7:0] cv);
    wr(2'd0, 8'h00);
    wr(2'd2, reload);
    wr(2'd0, cv);
    base = pcnt;
  endtask

  task automatic t_reset;
    for (int a = 0; a < 4; a++) rd(2'(a), 8'h00, "R1 reg reset");
    chk("R1 irq reset", {7'd0, irq}, 8'd0);
    chk("R1 pwm reset", {7'd0, pwm_out}, 8'd0);
  endtask

  task automatic t_freeze;
    start(8'h00, ctl(0, 3, 1, 1, 0));
    at(40); rd(2'd1, 8'd5, "R3 div8 count");
    wr(2'd0, ctl(0, 3, 0, 0, 0));
    at(55); rd(2'd1, 8'd5, "R4 frozen count");
    at(60); wr(2'd0, ctl(0, 3, 1, 0, 0));
    at(66); rd(2'd1, 8'd5, "R4 prescaler phase kept, before step");
    rd(2'd1, 8'd6, "R4 prescaler phase kept, step");
  endtask

  task automatic t_divide;
    start(8'h00, ctl(0, 0, 1, 1, 0));
    at(9); rd(2'd1, 8'd9, "R3 div1 count");
    start(8'h00, ctl(0, 3, 1, 1, 0));
    at(20); rd(2'd1, 8'd2, "R3 div8 count");
    start(8'h10, ctl(0, 7, 1, 1, 0));
    at(127); rd(2'd1, 8'h10, "R5 prescaler cleared, div128 before step");
    rd(2'd1, 8'h11, "R3 div128 step");
    rd(2'd0, ctl(0, 7, 1, 0, 0), "R5 force bit reads 0");
  endtask

  task automatic t_ext;
    ext_clk = 1'b0;
    start(8'h10, ctl(1, 0, 1, 1, 0));
    for (int i = 0; i < 5; i++) begin
      ext_clk = 1'b1; repeat (3) @(negedge clk);
      ext_clk = 1'b0; repeat (3) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    rd(2'd1, 8'h15, "R2 external edges counted");
    repeat (20) @(negedge clk);
    rd(2'd1, 8'h15, "R2 steady external level");
  endtask

  task automatic t_ovf;
    start(8'hF0, ctl(0, 0, 1, 1, 1));
    at(15); rd(2'd0, 8'h0A, "R7 flag clear before wrap");
    chk("R8 irq raised", {7'd0, irq}, 8'd1);
    rd(2'd0, 8'h0B, "R7 set wins over read");
    chk("R8 irq dropped after read", {7'd0, irq}, 8'd0);
    rd(2'd1, 8'hF1, "R6 wrap reloads");
    rd(2'd0, 8'h0A, "R7 flag cleared by read");
  endtask

  task automatic t_onfly;
    start(8'h00, ctl(0, 0, 1, 1, 0));
    at(10); wr(2'd1, 8'h80);
    rd(2'd1, 8'h80, "R9 write beats step");
    at(13); rd(2'd1, 8'h82, "R9 counting continues");
  endtask

  task automatic t_pwm;
    pwm_pol = 1'b1;
    wr(2'd3, 8'hF8);
    start(8'hF0, ctl(0, 0, 1, 1, 0));
    chk("R10 force sets polarity level", {7'd0, pwm_out}, 8'd1);
    wr(2'd3, 8'hF4);
    at(5);  chk("R10 duty write deferred", {7'd0, pwm_out}, 8'd1);
    at(7);  chk("R10 before compare", {7'd0, pwm_out}, 8'd1);
    at(8);  chk("R10 compare flips", {7'd0, pwm_out}, 8'd0);
    at(17); chk("R10 reload level", {7'd0, pwm_out}, 8'd1);
    at(19); chk("R10 new duty not yet", {7'd0, pwm_out}, 8'd1);
    at(20); chk("R10 new duty compare", {7'd0, pwm_out}, 8'd0);
    chk("R8 irq masked", {7'd0, irq}, 8'd0);
    rd(2'd0, 8'h09, "R8 flag set while masked");
    pwm_pol = 1'b0;
    at(32); chk("R10 reload low polarity", {7'd0, pwm_out}, 8'd0);
    at(36); chk("R10 compare to high", {7'd0, pwm_out}, 8'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_freeze;
    t_divide;
    t_ext;
    t_ovf;
    t_onfly;
    t_pwm;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule